// File: doc/BRIEF.md
# Configuration ROM Image CRC-8 Checker

This block validates the image held in a configuration serial ROM before the chip trusts any field inside it. On a start pulse it fetches the image one 16-bit word at a time through a simple request/acknowledge handshake. It runs a reflected CRC-8 over the bytes, compares the result with the checksum kept in the upper byte of the image's final word, and reports a verdict together with the revision byte held in the low byte of that same word.

ROMs come in two sizes. The block first tries the short image, whose length comes from the word-count input, or from a parameter when that input is zero. If the short image fails, the block restarts from word zero and checks a 220-word long image. The result is a corruption report only when the long image also fails. Each verdict is announced by a one-cycle done pulse, and the result flags stay valid until the next accepted start.

Top module: `srom_crc_checker`

## Requirements
- R1: After reset, fetch_req_o, done_o, crc_ok_o and crc_error_o are 0 and revision_o is 0x00.
- R2: The CRC register is seeded with 0xFF and updated one byte at a time, shifting out the LSB first with the reflected constant 0xAB. One byte XORed into a register value of 0x01 yields 0xF7, so a one-word image 0x08FE (count 1) passes with revision 0xFE.
- R3: Every word except the last is fed into the CRC low byte first (bits 7:0), then high byte (bits 15:8). Only the low byte of the last word is fed in, and the final CRC is XORed with 0xFF.
- R4: An image passes when the final CRC equals bits 15:8 of its last word. A pass sets crc_ok_o, and revision_o takes bits 7:0 of that last word.
- R5: When the short image fails, the block fetches words 0 to 219 again from address 0 and checks them as a long image with a fresh seed.
- R6: When both images fail, crc_error_o is set and revision_o shows bits 7:0 of word 219.
- R7: fetch_req_o stays high with fetch_addr_o unchanged until fetch_ack_i. Each acknowledged word advances the address by one within a pass.
- R8: done_o is a single-cycle pulse, and exactly one of crc_ok_o and crc_error_o is high when it fires. The two flags are never high together.
- R9: A start pulse during a check is ignored: the running check proceeds with its original length and its result is unchanged.
- R10: A word count of 0 selects the parameter default of 64 words for the short image.
- R11: An accepted start clears crc_ok_o and crc_error_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a check (accepted when idle) |
| len_i | input | 8 | Short image length in words; 0 selects the default |
| fetch_req_o | output | 1 | Word fetch request |
| fetch_addr_o | output | 8 | Word index being fetched |
| fetch_ack_i | input | 1 | Fetched word is valid on fetch_data_i |
| fetch_data_i | input | 16 | Fetched word |
| done_o | output | 1 | One-cycle pulse when a verdict is ready |
| crc_ok_o | output | 1 | Image checked good |
| crc_error_o | output | 1 | Both image sizes failed |
| revision_o | output | 8 | Low byte of the last word of the final pass |

## Verification
The bound checker watches on every cycle the handshake rules: the request holding its address until acknowledged, and the address stepping by one or restarting at zero. It also checks the verdict encoding (a single-cycle done with exactly one flag set), the flags clearing after an accepted start, and a mid-check start never ending a check early. The arithmetic itself can only be shown by the bench's scenarios. These cover the CRC value, the byte order inside each word, the short-then-long fallback, the default length and the revision byte. For each scenario a behavioural model predicts the verdict, the revision and the exact address sequence fetched.

// File: rtl/srom_crc_pkg.sv
package srom_crc_pkg;

    localparam logic [7:0] CRC_REFL_POLY = 8'hAB;
    localparam logic [7:0] CRC_SEED      = 8'hFF;
    localparam logic [7:0] CRC_XOROUT    = 8'hFF;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_FETCH
    } seq_state_e;

    typedef enum logic {
        PASS_SHORT,
        PASS_LONG
    } pass_e;

    typedef struct packed {
        logic       ok;
        logic       err;
        logic [7:0] rev;
    } verdict_t;

    // One byte through the reflected CRC-8, least significant bit first.
    function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_REFL_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/srom_crc_engine.sv
module srom_crc_engine
    import srom_crc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic              step_i,
    input  logic              last_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [7:0]        final_o
);
    localparam int NBYTES = WORD_W / 8;

    logic [7:0] crc_q;
    logic [7:0] chain [0:NBYTES];

    assign chain[0] = crc_q;

    // Byte lanes applied low lane first.
    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_lane
            assign chain[g+1] = crc8_byte(chain[g], word_i[8*g +: 8]);
        end
    endgenerate

    // The closing word contributes only its lowest lane.
    assign final_o = chain[1] ^ CRC_XOROUT;

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            crc_q <= CRC_SEED;
        end else if (step_i) begin
            crc_q <= last_i ? chain[1] : chain[NBYTES];
        end
    end

endmodule

// File: rtl/srom_fetch_seq.sv
module srom_fetch_seq
    import srom_crc_pkg::*;
#(
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             ack_i,
    input  logic             match_i,
    output logic             req_o,
    output logic [CNT_W-1:0] addr_o,
    output logic             last_o,
    output logic             init_o,
    output logic             finish_o,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_WORDS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_WORDS - 1);

    seq_state_e       state_q;
    pass_e            pass_q;
    logic [CNT_W-1:0] addr_q;
    logic [CNT_W-1:0] limit_q;

    logic accept;
    logic beat;
    logic end_beat;
    logic retry;

    assign busy_o   = (state_q == SEQ_FETCH);
    assign req_o    = busy_o;
    assign addr_o   = addr_q;
    assign last_o   = (addr_q == limit_q);
    assign accept   = start_i && !busy_o;
    assign beat     = busy_o && ack_i;
    assign end_beat = beat && last_o;
    assign retry    = end_beat && !match_i && (pass_q == PASS_SHORT);
    assign finish_o = end_beat && !retry;
    assign init_o   = accept || retry;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pass_q  <= PASS_SHORT;
            addr_q  <= '0;
            limit_q <= '0;
        end else if (accept) begin
            state_q <= SEQ_FETCH;
            pass_q  <= PASS_SHORT;
            addr_q  <= '0;
            limit_q <= (len_i == '0) ? SHORT_LAST : (len_i - 1'b1);
        end else if (retry) begin
            pass_q  <= PASS_LONG;
            addr_q  <= '0;
            limit_q <= LONG_LAST;
        end else if (finish_o) begin
            state_q <= SEQ_IDLE;
        end else if (beat) begin
            addr_q  <= addr_q + 1'b1;
        end
    end

endmodule

// File: rtl/srom_crc_checker.sv
module srom_crc_checker
    import srom_crc_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    localparam int CNT_W      = $clog2(LONG_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic              fetch_req_o,
    output logic [CNT_W-1:0]  fetch_addr_o,
    input  logic              fetch_ack_i,
    input  logic [WORD_W-1:0] fetch_data_i,
    output logic              done_o,
    output logic              crc_ok_o,
    output logic              crc_error_o,
    output logic [7:0]        revision_o
);
    logic       busy;
    logic       is_last;
    logic       crc_init;
    logic       finish;
    logic       match;
    logic [7:0] final_crc;
    logic       accept;

    verdict_t   res_q;
    logic       done_q;

    assign match  = (final_crc == fetch_data_i[WORD_W-1 -: 8]);
    assign accept = start_i && !busy;

    srom_fetch_seq #(
        .SHORT_WORDS (SHORT_WORDS),
        .LONG_WORDS  (LONG_WORDS),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .len_i    (len_i),
        .ack_i    (fetch_ack_i),
        .match_i  (match),
        .req_o    (fetch_req_o),
        .addr_o   (fetch_addr_o),
        .last_o   (is_last),
        .init_o   (crc_init),
        .finish_o (finish),
        .busy_o   (busy)
    );

    srom_crc_engine #(
        .WORD_W (WORD_W)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .init_i  (crc_init),
        .step_i  (fetch_ack_i && busy),
        .last_i  (is_last),
        .word_i  (fetch_data_i),
        .final_o (final_crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                res_q.ok  <= 1'b0;
                res_q.err <= 1'b0;
            end else if (finish) begin
                res_q.ok  <= match;
                res_q.err <= !match;
                res_q.rev <= fetch_data_i[7:0];
            end
        end
    end

    assign done_o      = done_q;
    assign crc_ok_o    = res_q.ok;
    assign crc_error_o = res_q.err;
    assign revision_o  = res_q.rev;

endmodule

// File: rtl/srom_crc_checker_sva.sv
module srom_crc_checker_sva #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             req,
    input logic             ack,
    input logic [CNT_W-1:0] addr,
    input logic             done,
    input logic             ok,
    input logic             err
);
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> req && $stable(addr));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        req && ack |=> !req || addr == '0 || addr == $past(addr) + 1'b1);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (ok != err));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ok && err));

    // R11
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> !ok && !err && !done);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        start && busy && !ack |=> busy);

endmodule

bind srom_crc_checker srom_crc_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .busy  (busy),
    .req   (fetch_req_o),
    .ack   (fetch_ack_i),
    .addr  (fetch_addr_o),
    .done  (done_o),
    .ok    (crc_ok_o),
    .err   (crc_error_o)
);

// File: tb/tb_srom_crc_checker.sv
`timescale 1ns/1ps
module tb_srom_crc_checker;
    localparam int SHORT_N = 64;
    localparam int LONG_N  = 220;
    localparam int CW      = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] len = '0;
    logic          ack = 1'b0;
    logic [15:0]   data = '0;
    logic          req;
    logic [CW-1:0] addr;
    logic          done, ok, err;
    logic [7:0]    rev;

    always #4 clk = ~clk;

    srom_crc_checker dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .len_i        (len),
        .fetch_req_o  (req),
        .fetch_addr_o (addr),
        .fetch_ack_i  (ack),
        .fetch_data_i (data),
        .done_o       (done),
        .crc_ok_o     (ok),
        .crc_error_o  (err),
        .revision_o   (rev)
    );

    logic [15:0] rom [0:255];
    int total = 0;
    int bad = 0;
    int lat_cfg = 0;
    int wait_cnt = 0;
    int seen[$];
    bit finished = 0;

    task automatic check_eq(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ROM responder: one-cycle acknowledge after lat_cfg idle cycles.
    always @(negedge clk) begin
        if (rst) begin
            ack = 1'b0;
            wait_cnt = 0;
        end else if (ack) begin
            ack = 1'b0;
        end else if (req) begin
            if (wait_cnt >= lat_cfg) begin
                ack = 1'b1;
                data = rom[addr];
                seen.push_back(int'(addr));
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // R8: per-clock comparison of the flag encoding with the model's rule.
    always @(negedge clk) begin
        if (!rst && !finished) check_eq("R8", "ok and error together", int'(ok && err), 0);
    end

    function automatic int ref_crc(int n);
        int c = 255;
        for (int w = 0; w < n; w++) begin
            int nb = (w == n - 1) ? 1 : 2;
            for (int b = 0; b < nb; b++) begin
                c = c ^ (int'(rom[w] >> (8 * b)) & 255);
                for (int k = 0; k < 8; k++) c = (c & 1) ? ((c >> 1) ^ 171) : (c >> 1);
            end
        end
        return c ^ 255;
    endfunction

    task automatic fill(int seed, int n);
        for (int i = 0; i < n; i++) rom[i] = 16'((i * 937 + seed * 4099) ^ (i << 7) ^ (seed << 3));
    endtask

    task automatic seal(int n, int revb);
        rom[n-1][7:0]  = 8'(revb);
        rom[n-1][15:8] = 8'(ref_crc(n));
    endtask

    task automatic run(int len_v, string tag, bit poke_busy);
        int n0, exp_ok, exp_rev, t, mism;
        int exp_seq[$];
        n0 = (len_v == 0) ? SHORT_N : len_v;
        for (int i = 0; i < n0; i++) exp_seq.push_back(i);
        if (ref_crc(n0) == int'(rom[n0-1][15:8])) begin
            exp_ok = 1;
            exp_rev = int'(rom[n0-1][7:0]);
        end else begin
            for (int i = 0; i < LONG_N; i++) exp_seq.push_back(i);
            exp_ok = (ref_crc(LONG_N) == int'(rom[LONG_N-1][15:8])) ? 1 : 0;
            exp_rev = int'(rom[LONG_N-1][7:0]);
        end
        seen.delete();
        @(negedge clk);
        start = 1'b1;
        len = CW'(len_v);
        @(negedge clk);
        start = 1'b0;
        check_eq("R11", "flags after start", int'({ok, err}), 0);
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            len = CW'(3);
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check_eq(tag, "done seen", int'(done), 1);
        check_eq(tag, "crc_ok", int'(ok), exp_ok);
        check_eq(tag, "crc_error", int'(err), 1 - exp_ok);
        check_eq(tag, "revision", int'(rev), exp_rev);
        check_eq("R7", "words fetched", seen.size(), exp_seq.size());
        mism = 0;
        for (int i = 0; i < seen.size() && i < exp_seq.size(); i++)
            if (seen[i] != exp_seq[i]) mism++;
        check_eq("R7", "address order mismatches", mism, 0);
        @(negedge clk);
        check_eq("R8", "done width", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) rom[i] = '0;
        repeat (5) @(negedge clk);
        // R1
        check_eq("R1", "req", int'(req), 0);
        check_eq("R1", "done", int'(done), 0);
        check_eq("R1", "flags", int'({ok, err}), 0);
        check_eq("R1", "revision", int'(rev), 0);
        rst = 1'b0;

        // R2: seed 0xFF ^ 0xFE = 0x01 -> 0xF7 -> inverted 0x08
        rom[0] = 16'h08FE;
        run(1, "R2", 0);
        check_eq("R2", "revision byte", int'(rev), 8'hFE);

        // R3, R4: full short image, back-to-back acknowledges
        fill(3, SHORT_N);
        seal(SHORT_N, 8'h05);
        run(SHORT_N, "R4", 0);

        // R10: zero length picks the default
        run(0, "R10", 0);

        // R3: odd size with slow ROM
        lat_cfg = 2;
        fill(7, 17);
        seal(17, 8'h02);
        run(17, "R3", 0);

        // R3: upper byte of a middle word matters
        lat_cfg = 0;
        fill(3, SHORT_N);
        seal(SHORT_N, 8'h05);
        rom[10] = rom[10] ^ 16'h0100;
        run(SHORT_N, "R3", 0);

        // R5: short image broken, long image intact
        fill(11, LONG_N);
        rom[SHORT_N-1][15:8] = 8'(ref_crc(SHORT_N) ^ 8'h5A);
        seal(LONG_N, 8'h04);
        run(SHORT_N, "R5", 0);
        check_eq("R5", "restart address", (seen.size() > SHORT_N) ? seen[SHORT_N] : -1, 0);

        // R6: both sizes broken
        fill(13, LONG_N);
        rom[SHORT_N-1][15:8] = 8'(ref_crc(SHORT_N) ^ 8'h01);
        rom[LONG_N-1][7:0]   = 8'h09;
        rom[LONG_N-1][15:8]  = 8'(ref_crc(LONG_N) ^ 8'h80);
        run(SHORT_N, "R6", 0);

        // R9 (R11 also checked on leaving the error state)
        lat_cfg = 1;
        fill(5, 40);
        seal(40, 8'h07);
        run(40, "R9", 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule